// File: doc/BRIEF.md
# Loop DAC Fault and Configuration Controller

This block sits between a serial frame receiver and the code input of a 4-20 mA loop-current DAC. It keeps the configuration registers and the last accepted 16-bit DAC code. It also collects fault pulses from the loop sense circuit and from the receiver. Every cycle it selects the code sent to the current output: either the last accepted DAC code, or one of two programmable alarm codes that push the loop current above or below the normal band.

The receiver presents each valid frame as a one-cycle write strobe. A tag input marks the frame as either a DAC code or a configuration word. A configuration word carries an 8-bit register address in bits 15:8 and 8 bits of data in bits 7:0. A key register guards the configuration space. While that space is open, DAC-code frames are refused, so the output cannot change during reprogramming.

Faults are reported on an active-low flag. Per-fault enable bits allow each fault class to be masked. An input pin selects whether communication faults drive the high or the low alarm code. When a fault goes away, the output returns to the last good code with no action from software.

Top module: `loopdac_fault_ctrl`

## Requirements
- R1: A configuration write to address 0x00 opens the configuration space when its data is 0x95 and closes it for any other data. After reset the space is closed. While it is closed, configuration writes to any other address have no effect.
- R2: A DAC-code frame (tag 0) updates the stored code only while the configuration space is closed. While it is open, such a frame is ignored.
- R3: Bits 2:1 of a write to address 0x01 act on the software error condition: 01 sets it, 10 clears it, and 00 or 11 leave it unchanged. Nothing of this field is stored.
- R4: Bit 0 of a write to address 0x01 resets the whole block on the following clock edge, exactly as the reset input does.
- R5: Address 0x02 holds the enables: bit 4 acknowledge enable, bit 3 frame fault, bit 2 parity fault, bit 1 channel fault, bit 0 loop fault. It resets to 0x1F. Bits 7:5 are reserved and ignore writes. The outputs `ack_en` and `fault_en` show bit 4 and bits 3:0.
- R6: The error condition is set by reset. Only an accepted DAC-code frame, or SERR=10, clears it. Any frame strobe clears latched channel, parity and frame faults. A fault pulse in the same cycle as a frame strobe wins.
- R7: Address 0x03 holds the low alarm byte and address 0x04 holds the high alarm byte. The alarm code is the byte followed by eight zero bits. The bytes reset to 0x24 and 0xE8.
- R8: An enabled loop fault always selects the low alarm code, even when other faults are also present.
- R9: With no enabled loop fault, the error condition or any enabled channel, parity or frame fault selects the high alarm code when `alarm_hi_sel` is 1 and the low alarm code when it is 0.
- R10: `err_n` is low only while the error condition or an enabled fault is active. A fault whose enable bit is 0 changes neither `err_n` nor `out_code`.
- R11: A loop fault stays active for LOOP_TMO clock edges, counted from the edge that captures its last pulse. It then clears by itself and the stored code is applied again.
- R12: With nothing active, `out_code` equals the last accepted DAC code. The stored code resets to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_stb | input | 1 | One-cycle strobe marking a valid received frame |
| wr_cfg | input | 1 | Frame tag: 1 configuration word, 0 DAC code |
| wr_word | input | 16 | Frame payload: DAC code, or address[15:8] and data[7:0] |
| flt_loop | input | 1 | Pulse: loop current cannot be sustained |
| flt_chan | input | 1 | Pulse: no channel activity within the monitor window |
| flt_par | input | 1 | Pulse: parity mismatch in a received frame |
| flt_frm | input | 1 | Pulse: bad symbol or bad frame length |
| alarm_hi_sel | input | 1 | Pin choosing the high (1) or low (0) alarm for non-loop faults |
| out_code | output | 16 | Code sent to the loop current DAC |
| err_n | output | 1 | Active-low error flag |
| ack_en | output | 1 | Acknowledge enable bit from the enable register |
| fault_en | output | 4 | Fault enables {frame, parity, channel, loop} |

## Verification
A corrupted key register appears as one of two failures: DAC frames that should be refused change `out_code`, or configuration writes that should be refused change the enable outputs or the alarm code seen during the next fault. Either shows within one frame. A stuck latched fault or error condition keeps `err_n` low and the alarm code on `out_code` after a clearing frame, which is visible in the first cycle after that frame. A loop timer that is off by one is caught by sampling exactly at the LOOP_TMO boundary edge.

// File: rtl/loopdac_pkg.sv
package loopdac_pkg;

    localparam int CODE_W = 16;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] ADDR_KEY    = 8'h00;
    localparam logic [BYTE_W-1:0] ADDR_CTRL   = 8'h01;
    localparam logic [BYTE_W-1:0] ADDR_ENABLE = 8'h02;
    localparam logic [BYTE_W-1:0] ADDR_ALM_LO = 8'h03;
    localparam logic [BYTE_W-1:0] ADDR_ALM_HI = 8'h04;

    localparam logic [BYTE_W-1:0] OPEN_KEY    = 8'h95;
    localparam logic [4:0]        ENABLE_RST  = 5'h1F;
    localparam logic [BYTE_W-1:0] ALM_LO_RST  = 8'h24;
    localparam logic [BYTE_W-1:0] ALM_HI_RST  = 8'hE8;

    typedef enum logic [1:0] {
        SERR_HOLD  = 2'b00,
        SERR_RAISE = 2'b01,
        SERR_DROP  = 2'b10,
        SERR_HOLD2 = 2'b11
    } serr_op_e;

    // bit order matches the enable register layout 4..0
    typedef struct packed {
        logic ack;
        logic frm;
        logic par;
        logic chan;
        logic loop;
    } enables_t;

    typedef struct packed {
        logic frm;
        logic par;
        logic chan;
        logic loop;
    } fault_vec_t;

    typedef struct packed {
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } cfg_word_t;

    function automatic logic [CODE_W-1:0] alarm_code(input logic [BYTE_W-1:0] b);
        return {b, {(CODE_W-BYTE_W){1'b0}}};
    endfunction

endpackage

// File: rtl/ldf_cfg_regs.sv
module ldf_cfg_regs
    import loopdac_pkg::*;
#(
    parameter logic [BYTE_W-1:0] KEY = OPEN_KEY
) (
    input  logic              clk,
    input  logic              rst_all,
    input  logic              wr_stb,
    input  logic              wr_cfg,
    input  logic [CODE_W-1:0] wr_word,
    output logic              unlocked,
    output enables_t          en,
    output logic [BYTE_W-1:0] alm_lo,
    output logic [BYTE_W-1:0] alm_hi,
    output logic [CODE_W-1:0] dac_q,
    output logic              dac_take,
    output logic              serr_set,
    output logic              serr_clr,
    output logic              soft_rst_q
);
    cfg_word_t cw;
    serr_op_e  op;
    logic      cfg_wr;
    logic      reg_wr;
    logic      ctrl_wr;

    assign cw       = cfg_word_t'(wr_word);
    assign op       = serr_op_e'(cw.data[2:1]);
    assign cfg_wr   = wr_stb & wr_cfg;
    assign reg_wr   = cfg_wr & unlocked;
    assign ctrl_wr  = reg_wr && (cw.addr == ADDR_CTRL);
    assign serr_set = ctrl_wr && (op == SERR_RAISE);
    assign serr_clr = ctrl_wr && (op == SERR_DROP);
    assign dac_take = wr_stb & ~wr_cfg & ~unlocked;

    always_ff @(posedge clk) begin
        if (rst_all) begin
            unlocked   <= 1'b0;
            en         <= enables_t'(ENABLE_RST);
            alm_lo     <= ALM_LO_RST;
            alm_hi     <= ALM_HI_RST;
            dac_q      <= '0;
            soft_rst_q <= 1'b0;
        end else begin
            if (cfg_wr && (cw.addr == ADDR_KEY))
                unlocked <= (cw.data == KEY);
            if (reg_wr && (cw.addr == ADDR_ENABLE))
                en <= enables_t'(cw.data[4:0]);
            if (reg_wr && (cw.addr == ADDR_ALM_LO))
                alm_lo <= cw.data;
            if (reg_wr && (cw.addr == ADDR_ALM_HI))
                alm_hi <= cw.data;
            if (dac_take)
                dac_q <= wr_word;
            soft_rst_q <= ctrl_wr & cw.data[0];
        end
    end

    assert_key_opens_R1: assert property (@(posedge clk) disable iff (rst_all)
        (cfg_wr && cw.addr == ADDR_KEY && cw.data == KEY) |=> unlocked);

    assert_open_blocks_dac_R2: assert property (@(posedge clk) disable iff (rst_all)
        (unlocked && wr_stb && !wr_cfg) |=> $stable(dac_q));

endmodule

// File: rtl/ldf_fault_track.sv
module ldf_fault_track
    import loopdac_pkg::*;
#(
    parameter int LOOP_TMO = 50
) (
    input  logic       clk,
    input  logic       rst_all,
    input  fault_vec_t flt,
    input  enables_t   en,
    input  logic       frame_seen,
    input  logic       dac_take,
    input  logic       serr_set,
    input  logic       serr_clr,
    output logic       loop_alarm,
    output logic       comm_alarm,
    output logic       err_n
);
    localparam int TMO_W  = $clog2(LOOP_TMO + 1);
    localparam int N_COMM = 3;

    logic              loop_act;
    logic [TMO_W-1:0]  tmo_cnt;
    logic              soft_err;
    logic [N_COMM-1:0] comm_lat;
    logic [N_COMM-1:0] comm_pulse;
    logic [N_COMM-1:0] comm_en;

    assign comm_pulse = {flt.frm, flt.par, flt.chan};
    assign comm_en    = {en.frm, en.par, en.chan};

    for (genvar g = 0; g < N_COMM; g++) begin : g_comm
        logic lat;
        always_ff @(posedge clk) begin
            if (rst_all)            lat <= 1'b0;
            else if (comm_pulse[g]) lat <= 1'b1;
            else if (frame_seen)    lat <= 1'b0;
        end
        assign comm_lat[g] = lat;
    end

    always_ff @(posedge clk) begin
        if (rst_all) begin
            loop_act <= 1'b0;
            tmo_cnt  <= '0;
        end else if (flt.loop) begin
            loop_act <= 1'b1;
            tmo_cnt  <= '0;
        end else if (loop_act) begin
            if (tmo_cnt == TMO_W'(LOOP_TMO - 1))
                loop_act <= 1'b0;
            else
                tmo_cnt <= tmo_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_all)                   soft_err <= 1'b1;
        else if (serr_set)             soft_err <= 1'b1;
        else if (serr_clr || dac_take) soft_err <= 1'b0;
    end

    assign loop_alarm = loop_act & en.loop;
    assign comm_alarm = soft_err | (|(comm_lat & comm_en));
    assign err_n      = ~(loop_alarm | comm_alarm);

    assert_loop_pulse_latches_R11: assert property (@(posedge clk) disable iff (rst_all)
        flt.loop |=> loop_act);

    assert_dac_frame_clears_error_R6: assert property (@(posedge clk) disable iff (rst_all)
        (dac_take && !serr_set) |=> !soft_err);

endmodule

// File: rtl/ldf_code_mux.sv
module ldf_code_mux
    import loopdac_pkg::*;
(
    input  logic              loop_alarm,
    input  logic              comm_alarm,
    input  logic              alarm_hi_sel,
    input  logic [BYTE_W-1:0] alm_lo,
    input  logic [BYTE_W-1:0] alm_hi,
    input  logic [CODE_W-1:0] dac_q,
    output logic [CODE_W-1:0] out_code
);
    always_comb begin
        if (loop_alarm)
            out_code = alarm_code(alm_lo);
        else if (comm_alarm)
            out_code = alarm_hi_sel ? alarm_code(alm_hi) : alarm_code(alm_lo);
        else
            out_code = dac_q;
    end
endmodule

// File: rtl/loopdac_fault_ctrl.sv
module loopdac_fault_ctrl
    import loopdac_pkg::*;
#(
    parameter int LOOP_TMO = 50
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_stb,
    input  logic        wr_cfg,
    input  logic [15:0] wr_word,
    input  logic        flt_loop,
    input  logic        flt_chan,
    input  logic        flt_par,
    input  logic        flt_frm,
    input  logic        alarm_hi_sel,
    output logic [15:0] out_code,
    output logic        err_n,
    output logic        ack_en,
    output logic [3:0]  fault_en
);
    logic              rst_all;
    logic              soft_rst_q;
    logic              unlocked;
    enables_t          en;
    logic [BYTE_W-1:0] alm_lo;
    logic [BYTE_W-1:0] alm_hi;
    logic [CODE_W-1:0] dac_q;
    logic              dac_take;
    logic              serr_set;
    logic              serr_clr;
    logic              loop_alarm;
    logic              comm_alarm;
    fault_vec_t        flt;

    assign rst_all = rst | soft_rst_q;
    assign flt     = '{frm: flt_frm, par: flt_par, chan: flt_chan, loop: flt_loop};

    ldf_cfg_regs #(.KEY(OPEN_KEY)) u_regs (
        .clk        (clk),
        .rst_all    (rst_all),
        .wr_stb     (wr_stb),
        .wr_cfg     (wr_cfg),
        .wr_word    (wr_word),
        .unlocked   (unlocked),
        .en         (en),
        .alm_lo     (alm_lo),
        .alm_hi     (alm_hi),
        .dac_q      (dac_q),
        .dac_take   (dac_take),
        .serr_set   (serr_set),
        .serr_clr   (serr_clr),
        .soft_rst_q (soft_rst_q)
    );

    ldf_fault_track #(.LOOP_TMO(LOOP_TMO)) u_track (
        .clk        (clk),
        .rst_all    (rst_all),
        .flt        (flt),
        .en         (en),
        .frame_seen (wr_stb),
        .dac_take   (dac_take),
        .serr_set   (serr_set),
        .serr_clr   (serr_clr),
        .loop_alarm (loop_alarm),
        .comm_alarm (comm_alarm),
        .err_n      (err_n)
    );

    ldf_code_mux u_mux (
        .loop_alarm   (loop_alarm),
        .comm_alarm   (comm_alarm),
        .alarm_hi_sel (alarm_hi_sel),
        .alm_lo       (alm_lo),
        .alm_hi       (alm_hi),
        .dac_q        (dac_q),
        .out_code     (out_code)
    );

    assign ack_en   = en.ack;
    assign fault_en = {en.frm, en.par, en.chan, en.loop};

    assert_loop_forces_low_R8: assert property (@(posedge clk) disable iff (rst_all)
        loop_alarm |-> (out_code == alarm_code(alm_lo)));

    assert_quiet_passes_code_R12: assert property (@(posedge clk) disable iff (rst_all)
        err_n |-> (out_code == dac_q));

endmodule

// File: tb/tb_loopdac_fault_ctrl.sv
module tb_loopdac_fault_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 50;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic        wr_cfg = 1'b0;
    logic [15:0] wr_word = '0;
    logic        flt_loop = 1'b0, flt_chan = 1'b0, flt_par = 1'b0, flt_frm = 1'b0;
    logic        alarm_hi_sel = 1'b0;
    logic [15:0] out_code;
    logic        err_n;
    logic        ack_en;
    logic [3:0]  fault_en;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;
    logic [15:0] exp_dac;
    logic [15:0] exp_lo, exp_hi;

    always #(CLK_PERIOD/2) clk = ~clk;

    loopdac_fault_ctrl #(.LOOP_TMO(TMO)) dut (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_cfg(wr_cfg), .wr_word(wr_word),
        .flt_loop(flt_loop), .flt_chan(flt_chan), .flt_par(flt_par), .flt_frm(flt_frm),
        .alarm_hi_sel(alarm_hi_sel), .out_code(out_code), .err_n(err_n),
        .ack_en(ack_en), .fault_en(fault_en)
    );

    task automatic check_out(string tag, logic [15:0] ec, logic ee);
        vectors++;
        if (out_code !== ec || err_n !== ee) begin
            misses++;
            $display("FAIL %s: out_code=%h err_n=%b expected out_code=%h err_n=%b",
                     tag, out_code, err_n, ec, ee);
        end
    endtask

    task automatic check_en(string tag, logic ea, logic [3:0] ef);
        vectors++;
        if (ack_en !== ea || fault_en !== ef) begin
            misses++;
            $display("FAIL %s: ack_en=%b fault_en=%h expected ack_en=%b fault_en=%h",
                     tag, ack_en, fault_en, ea, ef);
        end
    endtask

    task automatic send(logic cfg, logic [15:0] w);
        @(negedge clk);
        wr_stb = 1'b1; wr_cfg = cfg; wr_word = w;
        @(negedge clk);
        wr_stb = 1'b0; wr_cfg = 1'b0;
    endtask

    task automatic send_cfg(logic [7:0] a, logic [7:0] d);
        send(1'b1, {a, d});
    endtask

    // f = {frame, parity, channel, loop}
    task automatic pulse(logic [3:0] f);
        @(negedge clk);
        {flt_frm, flt_par, flt_chan, flt_loop} = f;
        @(negedge clk);
        {flt_frm, flt_par, flt_chan, flt_loop} = 4'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        exp_lo = 16'h2400; exp_hi = 16'hE800;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R6 R7 R9: error set at reset, low alarm default with pin 0
        check_out("R6_reset_error", exp_lo, 1'b0);
        check_en("R5_reset_enables", 1'b1, 4'hF);
        alarm_hi_sel = 1'b1; #1;
        check_out("R9_reset_pin_high", exp_hi, 1'b0);
        alarm_hi_sel = 1'b0;

        // R2 R6 R12: accepted DAC frame clears error and drives code
        exp_dac = 16'h1234;
        send(1'b0, exp_dac);
        check_out("R12_first_code", exp_dac, 1'b1);

        // R12 sweep of codes
        for (int i = 0; i < 32; i++) begin
            exp_dac = 16'(i * 16'h0841) ^ 16'(i << 11);
            send(1'b0, exp_dac);
            check_out("R12_sweep", exp_dac, 1'b1);
        end

        // R1 R2: open space, DAC frame refused
        send_cfg(8'h00, 8'h95);
        send(1'b0, 16'hAAAA);
        check_out("R2_refused_while_open", exp_dac, 1'b1);

        // R7: program alarm bytes, close, accept code
        send_cfg(8'h03, 8'h30);
        send_cfg(8'h04, 8'hD0);
        exp_lo = 16'h3000; exp_hi = 16'hD000;
        send_cfg(8'h00, 8'h00);
        exp_dac = 16'h5555;
        send(1'b0, exp_dac);
        check_out("R2_accepted_when_closed", exp_dac, 1'b1);

        // R9 R7: parity fault, pin selects alarm
        alarm_hi_sel = 1'b1;
        pulse(4'b0100);
        check_out("R9_parity_high", exp_hi, 1'b0);
        alarm_hi_sel = 1'b0; #1;
        check_out("R9_parity_low", exp_lo, 1'b0);

        // R6: frame clears latched parity fault
        exp_dac = 16'h6000;
        send(1'b0, exp_dac);
        check_out("R6_frame_clears", exp_dac, 1'b1);

        // R1: write while closed ignored
        send_cfg(8'h03, 8'h11);
        pulse(4'b1000);
        check_out("R1_closed_write_ignored", exp_lo, 1'b0);
        send(1'b0, exp_dac);
        check_out("R6_clear_frame_fault", exp_dac, 1'b1);

        // R8 R11: loop fault forces low even with pin high, then times out
        alarm_hi_sel = 1'b1;
        pulse(4'b0001);
        check_out("R8_loop_low", exp_lo, 1'b0);
        repeat (TMO - 1) @(negedge clk);
        check_out("R11_loop_last_edge", exp_lo, 1'b0);
        @(negedge clk);
        check_out("R11_loop_cleared", exp_dac, 1'b1);

        // R8: loop with channel together still low
        pulse(4'b0011);
        check_out("R8_loop_beats_chan", exp_lo, 1'b0);
        repeat (TMO) @(negedge clk);
        check_out("R9_chan_after_loop", exp_hi, 1'b0);
        send(1'b0, exp_dac);
        check_out("R6_chan_cleared", exp_dac, 1'b1);
        alarm_hi_sel = 1'b0;

        // R5 R10: mask channel, reserved bits set
        send_cfg(8'h00, 8'h95);
        send_cfg(8'h02, 8'hFD);
        check_en("R5_reserved_ignored", 1'b1, 4'hD);
        send_cfg(8'h00, 8'h01);
        pulse(4'b0010);
        check_out("R10_masked_chan", exp_dac, 1'b1);
        pulse(4'b1000);
        check_out("R10_enabled_frame", exp_lo, 1'b0);
        send(1'b0, exp_dac);

        send_cfg(8'h00, 8'h95);
        send_cfg(8'h02, 8'h0E);
        check_en("R5_ack_off", 1'b0, 4'hE);
        pulse(4'b0001);
        check_out("R10_masked_loop", exp_dac, 1'b1);
        repeat (TMO + 5) @(negedge clk);
        send_cfg(8'h02, 8'h1F);
        check_en("R5_restore", 1'b1, 4'hF);

        // R3: software error field, still open
        alarm_hi_sel = 1'b1;
        send_cfg(8'h01, 8'h02);
        check_out("R3_raise", exp_hi, 1'b0);
        send_cfg(8'h01, 8'h06);
        check_out("R3_hold11", exp_hi, 1'b0);
        send_cfg(8'h01, 8'h00);
        check_out("R3_hold00", exp_hi, 1'b0);
        send_cfg(8'h01, 8'h04);
        check_out("R3_drop", exp_dac, 1'b1);
        alarm_hi_sel = 1'b0;

        // R4: software reset
        send_cfg(8'h03, 8'h40);
        send_cfg(8'h01, 8'h01);
        @(negedge clk);
        exp_lo = 16'h2400; exp_hi = 16'hE800;
        check_out("R4_soft_reset", exp_lo, 1'b0);
        check_en("R4_soft_reset_en", 1'b1, 4'hF);
        exp_dac = 16'h4321;
        send(1'b0, exp_dac);
        check_out("R4_closed_after_reset", exp_dac, 1'b1);
        pulse(4'b0100);
        check_out("R7_default_low_again", exp_lo, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule